// File: doc/BRIEF.md
# Write Progress Counters

This block keeps three counters that let host software follow writes as they move through a memory-mapped-to-packet bridge. One counter ticks for every write transaction accepted on the slave side of the bridge. A second ticks for every write request packet passed on to the transport stage. The third tracks acknowledged writes that are still in flight: it goes up when such a request is issued and down when its response arrives. When it reads zero, every acknowledged write has been answered.

The bridge drives four single-cycle event strobes into the block. Software reads the counters through a small register port. The read data is combinational on the read address. Writing to the address of either event counter clears that counter. The in-flight counter cannot be written.

The in-flight counter is controlled by a three-state machine:

- **PS_EMPTY**: the count is zero.
- **PS_ACTIVE**: the count is between one and its maximum.
- **PS_FULL**: the count is at its maximum.

The machine moves between states as follows:

- PS_EMPTY goes to PS_ACTIVE on an issue without a completion.
- PS_ACTIVE goes to PS_FULL on an issue without a completion when the count is one below the maximum.
- PS_ACTIVE goes to PS_EMPTY on a completion without an issue when the count is one.
- PS_FULL goes back to PS_ACTIVE on a completion without an issue.
- Every other input combination holds both the state and the count.

The event counters are CNT_W bits wide (default 32). The in-flight counter is PEND_W bits wide (default 8).

Top module: `wr_track_ctrs`

## Requirements
- R1: After reset, all three counters read zero.
- R2: The accepted-write counter increases by one at each clock edge where `ev_accept` is high.
- R3: The packet counter increases by one at each clock edge where `ev_pkt_out` is high. This holds whichever packet type is sent, and a packet event alone never changes the in-flight counter.
- R4: At an edge where `ev_ackw_issue` is high and `ev_ackw_done` is low, the in-flight counter increases by one, unless it is at its maximum.
- R5: At an edge where `ev_ackw_done` is high and `ev_ackw_issue` is low, the in-flight counter decreases by one, unless it is zero.
- R6: At an edge where `ev_ackw_issue` and `ev_ackw_done` are both high, the in-flight counter keeps its value.
- R7: A completion without an issue leaves a zero in-flight count at zero.
- R8: An issue without a completion leaves an in-flight count of all ones (2^PEND_W-1) unchanged.
- R9: Each event counter wraps from all ones to zero with no other effect.
- R10: A register write (`wr_en` high) to address 0 clears the accepted-write counter, and one to address 1 clears the packet counter. The clear takes priority over an event on the same edge.
- R11: A register write to address 2 or 3 changes no counter.
- R12: The read map is fixed:
  - address 0 returns the accepted-write count;
  - address 1 returns the packet count;
  - address 2 returns the in-flight count, zero-extended;
  - address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_accept | input | 1 | Slave write transaction accepted |
| ev_pkt_out | input | 1 | Write request packet handed to transport |
| ev_ackw_issue | input | 1 | Acknowledged write request issued |
| ev_ackw_done | input | 1 | Acknowledged write response received |
| wr_en | input | 1 | Register write strobe (clear) |
| wr_addr | input | 2 | Register write address |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Read data for `rd_addr` |

## Verification
The bench sets up several corner cases on purpose:

- **Issue and completion on the same edge.** A design that lets one input win would drift the in-flight count up or down.
- **Completions at zero and issues at the maximum.** A wrapping design would jump to all ones, or back to zero, and hide writes that are still in flight.
- **Event-counter roll-over.** A counter that stuck at the maximum, or that disturbed its neighbour, would read wrong after all ones.
- **Clear on the same edge as an event.** A design that let the increment win would read one instead of zero.

Writes to the in-flight and reserved addresses are also checked. A design that decoded the address loosely would lose counts there.

// File: rtl/wr_track_pkg.sv
package wr_track_pkg;

    typedef enum logic [1:0] {
        PS_EMPTY  = 2'd0,
        PS_ACTIVE = 2'd1,
        PS_FULL   = 2'd2
    } pend_st_e;

    localparam logic [1:0] ADDR_ACC  = 2'd0;
    localparam logic [1:0] ADDR_PKT  = 2'd1;
    localparam logic [1:0] ADDR_PEND = 2'd2;

    localparam int NUM_EVT = 2;

endpackage

// File: rtl/evt_ctr.sv
module evt_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pend_tracker.sv
module pend_tracker
    import wr_track_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CMAX    = '1;
    localparam logic [W-1:0] CMAX_M1 = CMAX - 1'b1;
    localparam logic [W-1:0] ONE     = W'(1);

    pend_st_e st_q, st_d;
    logic [W-1:0] cnt_d;
    logic up_only, dn_only;

    assign up_only = up & ~dn;
    assign dn_only = dn & ~up;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt;
        unique case (st_q)
            PS_EMPTY: begin
                if (up_only) begin
                    cnt_d = cnt + 1'b1;
                    st_d  = (CMAX == ONE) ? PS_FULL : PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                if (up_only) begin
                    cnt_d = cnt + 1'b1;
                    if (cnt == CMAX_M1) st_d = PS_FULL;
                end else if (dn_only) begin
                    cnt_d = cnt - 1'b1;
                    if (cnt == ONE) st_d = PS_EMPTY;
                end
            end
            PS_FULL: begin
                if (dn_only) begin
                    cnt_d = cnt - 1'b1;
                    st_d  = (CMAX == ONE) ? PS_EMPTY : PS_ACTIVE;
                end
            end
            default: begin
                st_d  = PS_EMPTY;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

endmodule

// File: rtl/rd_mux.sv
module rd_mux
    import wr_track_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 8
) (
    input  logic [1:0]        addr,
    input  logic [CNT_W-1:0]  acc,
    input  logic [CNT_W-1:0]  pkt,
    input  logic [PEND_W-1:0] pend,
    output logic [CNT_W-1:0]  data
);

    always_comb begin
        unique case (addr)
            ADDR_ACC:  data = acc;
            ADDR_PKT:  data = pkt;
            ADDR_PEND: data = CNT_W'(pend);
            default:   data = '0;
        endcase
    end

endmodule

// File: rtl/wr_track_ctrs.sv
module wr_track_ctrs
    import wr_track_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_accept,
    input  logic             ev_pkt_out,
    input  logic             ev_ackw_issue,
    input  logic             ev_ackw_done,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data
);

    logic [NUM_EVT-1:0] evt_inc;
    logic [NUM_EVT-1:0] evt_clr;
    logic [CNT_W-1:0]   evt_q [NUM_EVT];
    logic [PEND_W-1:0]  pend_q;

    assign evt_inc = {ev_pkt_out, ev_accept};

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        assign evt_clr[g] = wr_en && (wr_addr == 2'(g));
        evt_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt_inc[g]),
            .clr   (evt_clr[g]),
            .cnt   (evt_q[g])
        );
    end

    pend_tracker #(.W(PEND_W)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (ev_ackw_issue),
        .dn    (ev_ackw_done),
        .cnt   (pend_q)
    );

    rd_mux #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_rd (
        .addr  (rd_addr),
        .acc   (evt_q[0]),
        .pkt   (evt_q[1]),
        .pend  (pend_q),
        .data  (rd_data)
    );

endmodule

// File: rtl/wr_track_chk.sv
module wr_track_chk #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_accept,
    input logic              ev_ackw_issue,
    input logic              ev_ackw_done,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [1:0]        rd_addr,
    input logic [CNT_W-1:0]  rd_data,
    input logic [CNT_W-1:0]  acc,
    input logic [PEND_W-1:0] pend
);

    localparam logic [PEND_W-1:0] PMAX = '1;

    AST_PEND_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ackw_issue && !ev_ackw_done && pend != PMAX) |=> (pend == $past(pend) + 1'b1)); // R4
    AST_PEND_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ackw_done && !ev_ackw_issue && pend != '0) |=> (pend == $past(pend) - 1'b1)); // R5
    AST_PEND_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ackw_issue && ev_ackw_done) |=> $stable(pend)); // R6
    AST_PEND_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0 && ev_ackw_done && !ev_ackw_issue) |=> (pend == '0)); // R7
    AST_PEND_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == PMAX && ev_ackw_issue && !ev_ackw_done) |=> (pend == PMAX)); // R8
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_accept && !(wr_en && wr_addr == 2'd0)) |=> (acc == $past(acc) + 1'b1)); // R2
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (acc == '0)); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd3) |-> (rd_data == '0)); // R12

endmodule

bind wr_track_ctrs wr_track_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_accept     (ev_accept),
    .ev_ackw_issue (ev_ackw_issue),
    .ev_ackw_done  (ev_ackw_done),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .acc           (evt_q[0]),
    .pend          (pend_q)
);

// File: tb/sim_wr_track_ctrs.sv
`timescale 1ns/100ps
module sim_wr_track_ctrs;

    localparam int CW = 12;
    localparam int PW = 6;
    localparam logic [CW-1:0] CMASK = '1;
    localparam int PMAX = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_accept = 0, ev_pkt_out = 0, ev_ackw_issue = 0, ev_ackw_done = 0;
    logic wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [CW-1:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    int m_acc = 0, m_pkt = 0, m_pend = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    wr_track_ctrs #(.CNT_W(CW), .PEND_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_accept(ev_accept), .ev_pkt_out(ev_pkt_out),
        .ev_ackw_issue(ev_ackw_issue), .ev_ackw_done(ev_ackw_done),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int nxt_evt(int v, bit inc, bit clr);
        if (clr) return 0;
        if (inc) return (v + 1) & int'(CMASK);
        return v;
    endfunction

    function automatic int nxt_pend(int v, bit up, bit dn);
        if (up && !dn && v < PMAX) return v + 1;
        if (dn && !up && v > 0) return v - 1;
        return v;
    endfunction

    task automatic cmp(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // drive during low phase, apply one edge, update model
    task automatic cyc(bit a, bit p, bit i, bit d, bit we, logic [1:0] wa);
        @(negedge clk);
        ev_accept = a; ev_pkt_out = p; ev_ackw_issue = i; ev_ackw_done = d;
        wr_en = we; wr_addr = wa;
        @(posedge clk);
        m_acc  = nxt_evt(m_acc, a, we && wa == 2'd0);
        m_pkt  = nxt_evt(m_pkt, p, we && wa == 2'd1);
        m_pend = nxt_pend(m_pend, i, d);
        @(negedge clk);
        ev_accept = 0; ev_pkt_out = 0; ev_ackw_issue = 0; ev_ackw_done = 0; wr_en = 0;
    endtask

    task automatic rd_all(string tag);
        #0.3 rd_addr = 2'd0; #0.3 cmp({tag, " R2 acc"},  int'(rd_data), m_acc);
        rd_addr = 2'd1;      #0.3 cmp({tag, " R3 pkt"},  int'(rd_data), m_pkt);
        rd_addr = 2'd2;      #0.3 cmp({tag, " R4 pend"}, int'(rd_data), m_pend);
        rd_addr = 2'd3;      #0.3 cmp({tag, " R12 rsvd"}, int'(rd_data), 0);
        rd_addr = 2'd0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        rd_all("R1 reset");

        // R2/R3/R4 simple increments
        cyc(1, 0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0, 0);
        rd_all("R2 R3 R4 single");
        // R3: packet-only event leaves pending alone
        cyc(0, 1, 0, 0, 0, 0); rd_all("R3 pkt only");
        // R6 both together
        cyc(0, 0, 1, 1, 0, 0); rd_all("R6 both");
        // R5 decrement, R7 floor
        cyc(0, 0, 0, 1, 0, 0); rd_all("R5 dec");
        cyc(0, 0, 0, 1, 0, 0); rd_all("R7 floor");
        cyc(0, 0, 1, 1, 0, 0); rd_all("R6 both at zero");
        // R8 ceiling
        for (int k = 0; k < PMAX + 5; k++) cyc(0, 0, 1, 0, 0, 0);
        rd_all("R8 ceiling");
        cmp("R8 pend max", m_pend, PMAX);
        cyc(0, 0, 1, 1, 0, 0); rd_all("R6 both at max");
        // R11 writes to pending / reserved
        cyc(1, 1, 0, 0, 1, 2'd2); rd_all("R11 wr addr2");
        cyc(0, 0, 0, 0, 1, 2'd3); rd_all("R11 wr addr3");
        // R10 clear with event same edge
        cyc(1, 1, 0, 0, 1, 2'd0); rd_all("R10 clr acc");
        cyc(1, 1, 0, 0, 1, 2'd1); rd_all("R10 clr pkt");
        // R9 wrap
        cyc(0, 0, 0, 0, 1, 2'd0);
        for (int k = 0; k < int'(CMASK); k++) cyc(1, 0, 0, 0, 0, 0);
        rd_all("R9 all ones");
        cyc(1, 0, 0, 0, 0, 0);
        rd_all("R9 wrap");
        cmp("R9 model wrap", m_acc, 0);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            bit we;
            we = ($urandom % 40) == 0;
            cyc($urandom % 2, $urandom % 2, ($urandom % 3) != 0, ($urandom % 3) == 0,
                we, 2'($urandom % 4));
            if (k % 97 == 0) rd_all("R2 R3 R5 R10 random");
        end
        for (int k = 0; k < 200; k++) cyc(0, 0, $urandom % 4 == 0, 1, 0, 0);
        rd_all("R5 drain");
        cmp("R7 drained", m_pend, 0);

        done_flag = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule